// File: doc/BRIEF.md
# GPIO Bank with Sleep-State Hold

This block is a bank of general-purpose I/O pins controlled through a simple single-cycle register bus. Software sets each pin's direction. It changes output data through separate set and clear writes, and it can read the synchronized level of every pin at any time. Rising and falling edges can be enabled separately for each pin. A detected edge sets a sticky status bit. The status bits combine into an interrupt request and, for the low sixteen pins while the bank is asleep, into a wake-up request.

Each pin has a 2-bit source select. The select routes the pin's output either from the bank's own data register or from one of three alternate-function sources. It also steers the synchronized input to the matching alternate input. The direction register always sets the output enable, whatever the select.

When the sleep input rises, the bank captures its programmed sleep values and the current direction, and drives them onto the pins. It keeps driving them after the sleep input falls, until software writes the re-init flag. A configurable set of dedicated pins is excepted: these return to normal routing as soon as the sleep input is low.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, pin_out, pin_oe, irq and wake are all 0, and every readable register reads 0.
- R2: Reading word address 0 returns the pin inputs through a two-flop synchronizer. A change applied before clock edge k is visible after edge k+1. The value is returned whatever the direction of the pin.
- R3: Writing address 2 sets the output data bits that carry a 1. Writing address 3 clears the output data bits that carry a 1. Bits written as 0 leave their pins unchanged. With select 0, pin_out shows the output data. pin_oe shows the direction register (address 1, 1 = output).
- R4: A rising edge sets its bit in the edge status register (address 6) when the pin's bit in address 4 is enabled. A falling edge does the same when the pin's bit in address 5 is enabled. The status bit is visible after the third clock edge following the pin change. An edge that is not enabled sets nothing.
- R5: Writing 1 to an edge status bit clears it, and writing 0 leaves it alone. A status bit stays set until it is cleared. If an edge is detected in the same cycle as a clear, the bit stays set.
- R6: irq is 1 exactly when any edge status bit is set.
- R7: wake goes to 1 when an edge on pins 0 to 15 is detected while sleep_req is high. Edges on pins 16 and above never raise wake, and edges detected while awake never raise wake. wake drops when the matching status bit is cleared.
- R8: Each pin has a 2-bit select. Pin i below 16 uses bits [2i+1:2i] of address 7. Pin 16+j uses bits [2j+1:2j] of address 8. Select 0 routes the output data to the pin. Select k (1 to 3) routes alt_out[3i+k-1] to the pin and drives alt_in[3i+k-1] with the synchronized pin level. The other alt_in bits of that pin are 0. pin_oe still follows the direction register.
- R9: At the first clock edge that samples sleep_req high, the pins start driving the sleep values (address 9). pin_oe starts showing the direction captured at that edge.
- R10: After entering sleep, the pins keep the captured values even if software writes direction, set or clear. The hold ends at the edge that writes 1 to bit 0 of address 10 while sleep_req is low. A re-init write made while sleep_req is high is ignored. Bit 0 of address 10 reads 1 while the hold is active.
- R11: The pins in DED_MASK (pins 20 to 23 by default) return to normal output and direction as soon as sleep_req is low, without waiting for the re-init write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables (1 = drive) |
| alt_out | input | 3*NPINS | Alternate-function output sources, three per pin |
| alt_in | output | 3*NPINS | Alternate-function input routes, three per pin |
| sleep_req | input | 1 | High while the bank is in sleep |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The hardest state to reach is an edge detection that lands in exactly the same cycle as a write-one-to-clear of that status bit. The bench reaches it by counting the three register stages from the pin to the status bit. It then issues the clear on the third edge after a falling transition. A second hard sequence is the wake-up hold: the bench writes direction and set data during sleep, tries a re-init that must be ignored, drops sleep_req, and checks the dedicated pins between the drop and the re-init write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 4;
    localparam int SEL_W     = 2;
    localparam int ALT_SRCS  = 3;
    localparam int WAKE_PINS = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL   = 4'd0,
        REG_DIR     = 4'd1,
        REG_SET     = 4'd2,
        REG_CLR     = 4'd3,
        REG_RISE    = 4'd4,
        REG_FALL    = 4'd5,
        REG_EDGE    = 4'd6,
        REG_ALT_LO  = 4'd7,
        REG_ALT_HI  = 4'd8,
        REG_SLPVAL  = 4'd9,
        REG_SLPSTAT = 4'd10
    } reg_addr_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_GPIO = 2'd0,
        SRC_ALT1 = 2'd1,
        SRC_ALT2 = 2'd2,
        SRC_ALT3 = 2'd3
    } pin_src_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
    } bus_req_t;

    function automatic logic hit(bus_req_t r, reg_addr_e a);
        return r.wr && (r.addr == a);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int N     = 24,
    parameter int NWAKE = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic [N-1:0] clr,
    input  logic         sleep,
    output logic [N-1:0] status,
    output logic         irq,
    output logic         wake
);
    logic [N-1:0]     prev_q, stat_q, det;
    logic [NWAKE-1:0] wk_q;

    always_comb det = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
            wk_q   <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~clr) | det;
            wk_q   <= (wk_q & ~clr[NWAKE-1:0]) | (det[NWAKE-1:0] & {NWAKE{sleep}});
        end
    end

    assign status = stat_q;
    assign irq    = |stat_q;
    assign wake   = |wk_q;
endmodule

// File: rtl/gpio_altmux.sv
module gpio_altmux
    import gpio_bank_pkg::*;
#(
    parameter int N = 24
) (
    input  logic [SEL_W*N-1:0]    sel,
    input  logic [N-1:0]          gpio_out,
    input  logic [ALT_SRCS*N-1:0] alt_out,
    input  logic [N-1:0]          lvl,
    output logic [N-1:0]          mux_out,
    output logic [ALT_SRCS*N-1:0] alt_in
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_src_e src;
        logic     m;
        assign src = pin_src_e'(sel[SEL_W*i +: SEL_W]);

        always_comb begin
            case (src)
                SRC_ALT1: m = alt_out[ALT_SRCS*i];
                SRC_ALT2: m = alt_out[ALT_SRCS*i+1];
                SRC_ALT3: m = alt_out[ALT_SRCS*i+2];
                default:  m = gpio_out[i];
            endcase
        end
        assign mux_out[i] = m;

        for (genvar k = 0; k < ALT_SRCS; k++) begin : g_src
            assign alt_in[ALT_SRCS*i+k] = lvl[i] & (src == pin_src_e'(k + 1));
        end
    end
endmodule

// File: rtl/gpio_outctl.sv
module gpio_outctl
    import gpio_bank_pkg::*;
#(
    parameter int           N        = 24,
    parameter logic [N-1:0] DED_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    input  logic [N-1:0] sleep_val,
    input  logic         sleep,
    input  logic [N-1:0] normal_out,
    output logic [N-1:0] data_q,
    output logic [N-1:0] dir_q,
    output logic         hold_q,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe
);
    logic [N-1:0] slp_out_q, slp_oe_q, hold_pin;
    logic         wr_dir, wr_set, wr_clr, wr_reinit;

    assign wr_dir    = hit(req, REG_DIR);
    assign wr_set    = hit(req, REG_SET);
    assign wr_clr    = hit(req, REG_CLR);
    assign wr_reinit = hit(req, REG_SLPSTAT) && req.data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            dir_q     <= '0;
            hold_q    <= 1'b0;
            slp_out_q <= '0;
            slp_oe_q  <= '0;
        end else begin
            if (wr_dir) dir_q  <= req.data[N-1:0];
            if (wr_set) data_q <= data_q | req.data[N-1:0];
            if (wr_clr) data_q <= data_q & ~req.data[N-1:0];
            if (sleep && !hold_q) begin
                hold_q    <= 1'b1;
                slp_out_q <= sleep_val;
                slp_oe_q  <= dir_q;
            end else if (wr_reinit && !sleep) begin
                hold_q <= 1'b0;
            end
        end
    end

    // dedicated pins leave the hold as soon as sleep drops
    assign hold_pin = {N{hold_q}} & ({N{sleep}} | ~DED_MASK);
    assign pin_out  = (hold_pin & slp_out_q) | (~hold_pin & normal_out);
    assign pin_oe   = (hold_pin & slp_oe_q)  | (~hold_pin & dir_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int                NPINS    = 24,
    parameter logic [NPINS-1:0]  DED_MASK = 24'hF00000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    input  logic [NPINS-1:0]          pin_in,
    output logic [NPINS-1:0]          pin_out,
    output logic [NPINS-1:0]          pin_oe,
    input  logic [ALT_SRCS*NPINS-1:0] alt_out,
    output logic [ALT_SRCS*NPINS-1:0] alt_in,
    input  logic                      sleep_req,
    output logic                      irq,
    output logic                      wake
);
    localparam int NWAKE   = (NPINS < WAKE_PINS) ? NPINS : WAKE_PINS;
    localparam int SEL_BITS = SEL_W * NPINS;
    localparam int SEL_PAD  = 2 * BUS_W;

    bus_req_t           req;
    logic [NPINS-1:0]   lvl, rise_q, fall_q, slpval_q, status, edge_clr;
    logic [NPINS-1:0]   out_data, dir_q, normal_out;
    logic [SEL_BITS-1:0] sel_q;
    logic [SEL_PAD-1:0]  sel_pad, sel_nxt;
    logic               hold_q;

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
    );

    // configuration registers owned by the top
    assign sel_pad = SEL_PAD'(sel_q);
    always_comb begin
        sel_nxt = sel_pad;
        if (hit(req, REG_ALT_LO)) sel_nxt[BUS_W-1:0]     = bus_wdata;
        if (hit(req, REG_ALT_HI)) sel_nxt[SEL_PAD-1:BUS_W] = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q   <= '0;
            fall_q   <= '0;
            slpval_q <= '0;
            sel_q    <= '0;
        end else begin
            if (hit(req, REG_RISE))   rise_q   <= bus_wdata[NPINS-1:0];
            if (hit(req, REG_FALL))   fall_q   <= bus_wdata[NPINS-1:0];
            if (hit(req, REG_SLPVAL)) slpval_q <= bus_wdata[NPINS-1:0];
            sel_q <= sel_nxt[SEL_BITS-1:0];
        end
    end

    assign edge_clr = hit(req, REG_EDGE) ? bus_wdata[NPINS-1:0] : '0;

    gpio_edge #(.N(NPINS), .NWAKE(NWAKE)) u_edge (
        .clk(clk), .rst(rst), .lvl(lvl), .rise_en(rise_q), .fall_en(fall_q),
        .clr(edge_clr), .sleep(sleep_req), .status(status), .irq(irq), .wake(wake)
    );

    gpio_altmux #(.N(NPINS)) u_mux (
        .sel(sel_q), .gpio_out(out_data), .alt_out(alt_out), .lvl(lvl),
        .mux_out(normal_out), .alt_in(alt_in)
    );

    gpio_outctl #(.N(NPINS), .DED_MASK(DED_MASK)) u_out (
        .clk(clk), .rst(rst), .req(req), .sleep_val(slpval_q), .sleep(sleep_req),
        .normal_out(normal_out), .data_q(out_data), .dir_q(dir_q), .hold_q(hold_q),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            REG_LEVEL:   bus_rdata[NPINS-1:0] = lvl;
            REG_DIR:     bus_rdata[NPINS-1:0] = dir_q;
            REG_RISE:    bus_rdata[NPINS-1:0] = rise_q;
            REG_FALL:    bus_rdata[NPINS-1:0] = fall_q;
            REG_EDGE:    bus_rdata[NPINS-1:0] = status;
            REG_ALT_LO:  bus_rdata = sel_pad[BUS_W-1:0];
            REG_ALT_HI:  bus_rdata = sel_pad[SEL_PAD-1:BUS_W];
            REG_SLPVAL:  bus_rdata[NPINS-1:0] = slpval_q;
            REG_SLPSTAT: bus_rdata[0] = hold_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int           N        = 24,
    parameter logic [N-1:0] DED_MASK = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [N-1:0]      pin_in,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic              sleep_req,
    input logic              irq,
    input logic              wake,
    input logic [N-1:0]      out_q,
    input logic              hold_q
);
    logic [1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst) since_q <= '0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq && !wake && pin_oe == '0)); // R1

    AST_LEVEL_SYNC: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && bus_addr == REG_LEVEL) |-> bus_rdata[N-1:0] == $past(pin_in, 2)); // R2

    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_SET) |=>
        (out_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])); // R3

    AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_CLR) |=> (out_q & $past(bus_wdata[N-1:0])) == '0); // R3

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_wr && bus_addr == REG_EDGE)) |=> irq); // R5

    AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        wake |-> irq); // R7

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !(bus_wr && bus_addr == REG_SLPSTAT && bus_wdata[0])) |=>
        ((pin_out & ~DED_MASK) == $past(pin_out & ~DED_MASK))); // R10

    AST_REINIT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (hold_q && sleep_req) |=> hold_q); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.N(NPINS), .DED_MASK(DED_MASK)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .sleep_req(sleep_req), .irq(irq), .wake(wake), .out_q(out_data), .hold_q(hold_q)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    import gpio_bank_pkg::*;

    localparam int N = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N-1:0]      pin_in = '0;
    logic [N-1:0]      pin_out, pin_oe;
    logic [3*N-1:0]    alt_out = '0;
    logic [3*N-1:0]    alt_in;
    logic              sleep_req = 1'b0;
    logic              irq, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_out(alt_out), .alt_in(alt_in), .sleep_req(sleep_req), .irq(irq), .wake(wake)
    );

    task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic chkreg(string tag, logic [3:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq/wake", {irq, wake}, 0);
        for (int a = 0; a < 11; a++) chkreg("R1 register", a[3:0], 0);
    endtask

    task automatic t_level;
        pin_in = 24'h5A3C81;
        cyc(1);
        chkreg("R2 level after one edge", REG_LEVEL, 0);
        cyc(1);
        chkreg("R2 level after two edges", REG_LEVEL, 32'h5A3C81);
        wr(REG_DIR, 32'hFFFFFF);
        chkreg("R2 level with outputs", REG_LEVEL, 32'h5A3C81);
        wr(REG_DIR, 0);
    endtask

    task automatic t_setclr;
        wr(REG_DIR, 32'hFFFFFF);
        wr(REG_SET, 32'h0000F0);
        chk("R3 set", pin_out, 24'h0000F0);
        chk("R3 oe", pin_oe, 24'hFFFFFF);
        wr(REG_SET, 32'h000003);
        chk("R3 set merge", pin_out, 24'h0000F3);
        wr(REG_CLR, 32'h000030);
        chk("R3 clear", pin_out, 24'h0000C3);
        wr(REG_CLR, 0);
        chk("R3 clear zero ignored", pin_out, 24'h0000C3);
        wr(REG_SET, 0);
        chk("R3 set zero ignored", pin_out, 24'h0000C3);
        chkreg("R3 dir readback", REG_DIR, 32'hFFFFFF);
        wr(REG_CLR, 32'hFFFFFF);
        wr(REG_DIR, 0);
        chk("R3 oe off", pin_oe, 0);
    endtask

    task automatic t_edges;
        pin_in = '0;
        cyc(3);
        chkreg("R4 disabled edges", REG_EDGE, 0);
        wr(REG_RISE, 32'h0F);
        wr(REG_FALL, 32'hF1);
        pin_in = 24'hFF;
        cyc(2);
        chkreg("R4 status not yet", REG_EDGE, 0);
        chk("R6 irq low", irq, 0);
        cyc(1);
        chkreg("R4 rising", REG_EDGE, 32'h0F);
        chk("R6 irq high", irq, 1);
        pin_in = '0;
        cyc(3);
        chkreg("R4 falling", REG_EDGE, 32'hFF);
        wr(REG_EDGE, 32'h0F);
        chkreg("R5 partial clear", REG_EDGE, 32'hF0);
        wr(REG_EDGE, 0);
        chkreg("R5 zero write", REG_EDGE, 32'hF0);
        chk("R6 irq remains", irq, 1);
        wr(REG_EDGE, 32'hF0);
        chkreg("R5 cleared", REG_EDGE, 0);
        chk("R6 irq dropped", irq, 0);
        pin_in = 24'h1;
        cyc(3);
        chkreg("R4 pin0 rise", REG_EDGE, 1);
        pin_in = '0;
        cyc(2);
        wr(REG_EDGE, 1);
        chkreg("R5 set wins over clear", REG_EDGE, 1);
        wr(REG_EDGE, 1);
        chkreg("R5 clear after", REG_EDGE, 0);
        wr(REG_RISE, 0);
        wr(REG_FALL, 0);
    endtask

    task automatic t_alt;
        logic [71:0] exp_in;
        wr(REG_DIR, 32'hFFFFFF);
        wr(REG_SET, 32'h1);
        alt_out = '0;
        alt_out[0] = 1'b1; alt_out[3] = 1'b1; alt_out[8] = 1'b1; alt_out[51] = 1'b1;
        wr(REG_ALT_LO, 32'h36);
        wr(REG_ALT_HI, 32'h4);
        chk("R8 alt routing", pin_out, 24'h020006);
        chk("R8 oe from dir", pin_oe, 24'hFFFFFF);
        chkreg("R8 alt lo readback", REG_ALT_LO, 32'h36);
        chkreg("R8 alt hi readback", REG_ALT_HI, 32'h4);
        wr(REG_DIR, 0);
        chk("R8 oe off in alt", pin_oe, 0);
        chk("R8 routing kept", pin_out, 24'h020006);
        pin_in = 24'h020007;
        cyc(2);
        exp_in = '0;
        exp_in[1] = 1'b1; exp_in[3] = 1'b1; exp_in[8] = 1'b1; exp_in[51] = 1'b1;
        chk("R8 alt inputs", alt_in, exp_in);
        wr(REG_ALT_LO, 0);
        wr(REG_ALT_HI, 0);
        chk("R8 back to gpio", pin_out, 24'h000001);
        pin_in = '0;
        alt_out = '0;
        wr(REG_CLR, 32'hFFFFFF);
        cyc(2);
    endtask

    task automatic t_sleep;
        wr(REG_DIR, 32'hF000FF);
        wr(REG_SET, 32'h300055);
        chk("R3 pre-sleep data", pin_out, 24'h300055);
        wr(REG_SLPVAL, 32'hC000AA);
        chkreg("R9 sleep value readback", REG_SLPVAL, 32'hC000AA);
        sleep_req = 1'b1;
        #1;
        chk("R9 before entry edge", pin_out, 24'h300055);
        @(negedge clk);
        chk("R9 sleep values", pin_out, 24'hC000AA);
        chk("R9 sleep oe", pin_oe, 24'hF000FF);
        chkreg("R10 hold flag", REG_SLPSTAT, 1);
        wr(REG_DIR, 32'hFFFFFF);
        wr(REG_SET, 32'h000F00);
        chk("R10 writes do not reach pins", pin_out, 24'hC000AA);
        chk("R10 dir does not reach pins", pin_oe, 24'hF000FF);
        wr(REG_SLPSTAT, 1);
        chkreg("R10 reinit ignored in sleep", REG_SLPSTAT, 1);
        chk("R10 still held", pin_out, 24'hC000AA);
        sleep_req = 1'b0;
        #1;
        chk("R11 dedicated revert", pin_out, 24'h3000AA);
        chk("R11 dedicated oe", pin_oe, 24'hF000FF);
        cyc(1);
        chk("R10 held after wake", pin_out, 24'h3000AA);
        chkreg("R10 hold after wake", REG_SLPSTAT, 1);
        wr(REG_SLPSTAT, 1);
        chk("R10 released data", pin_out, 24'h300F55);
        chk("R10 released oe", pin_oe, 24'hFFFFFF);
        chkreg("R10 flag cleared", REG_SLPSTAT, 0);
        wr(REG_CLR, 32'hFFFFFF);
        wr(REG_DIR, 0);
    endtask

    task automatic t_wake;
        pin_in = '0;
        wr(REG_RISE, 32'h010001);
        pin_in = 24'h000001;
        cyc(3);
        chk("R6 irq awake", irq, 1);
        chk("R7 no wake while awake", wake, 0);
        wr(REG_EDGE, 32'hFFFFFF);
        chk("R6 irq cleared", irq, 0);
        pin_in = '0;
        cyc(3);
        sleep_req = 1'b1;
        cyc(1);
        pin_in = 24'h010000;
        cyc(3);
        chk("R6 irq high pin", irq, 1);
        chk("R7 high pin no wake", wake, 0);
        chkreg("R4 pin16 status", REG_EDGE, 32'h010000);
        wr(REG_EDGE, 32'hFFFFFF);
        pin_in = 24'h010001;
        cyc(2);
        chk("R7 wake not yet", wake, 0);
        cyc(1);
        chk("R7 wake raised", wake, 1);
        wr(REG_EDGE, 1);
        chk("R7 wake cleared", wake, 0);
        sleep_req = 1'b0;
        wr(REG_SLPSTAT, 1);
        chkreg("R10 exit", REG_SLPSTAT, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_level();
        t_setclr();
        t_edges();
        t_alt();
        t_sleep();
        t_wake();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule